// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for a load or store in a 32-bit, byte-addressed RISC datapath, together with the new base-register value and the flag that commits it. The caller provides a base value, an offset and a handful of control fields. The offset can be a zero-extended immediate or a second register value, and it can be added to the base or subtracted from it. Three indexing modes decide which value goes to memory and whether the base register is updated.

In plain offset mode the sum goes to memory and the base is left alone. Pre-indexed mode sends the sum to memory and also writes it back to the base. Post-indexed mode sends the untouched base to memory and writes the sum back afterwards. Register-indirect addressing is offset mode with a zero offset. Alongside the address the block produces a per-byte lane-enable mask for byte, halfword and word accesses, and it flags halfword and word accesses that are not aligned to their size. The block is purely combinational. It has no clock and no state.

Top module: `lsag_top`

## Requirements
- R1: With mode code 0 (offset), addr_o equals base_i plus or minus the offset, modulo 2^32, and wb_en_o is 0.
- R2: With mode code 1 (pre-indexed), addr_o equals base_i plus or minus the offset, wb_base_o carries that same value, and wb_en_o is 1.
- R3: With mode code 2 (post-indexed), addr_o equals base_i unchanged, wb_base_o equals base_i plus or minus the offset, and wb_en_o is 1.
- R4: The offset is roff_i when use_reg_i is 1, and imm_i zero-extended to 32 bits when use_reg_i is 0. When sub_i is 1 the offset is subtracted from the base instead of added, wrapping modulo 2^32. wb_base_o always holds this base-plus-or-minus-offset value.
- R5: With size code 0 (byte), be_o is one-hot, and bit n is set when addr_o[1:0] equals n.
- R6: With size code 1 (halfword), be_o is 4'b0011 when addr_o[1] is 0 and 4'b1100 when addr_o[1] is 1.
- R7: With size code 2 (word), be_o is 4'b1111.
- R8: misalign_o is 1 for a halfword access with addr_o[0] set, or for a word access with addr_o[1:0] nonzero. It is never 1 for a byte access. The address is produced unchanged whether or not the access is misaligned.
- R9: The reserved mode code 3 behaves as offset mode, with no writeback. The reserved size code 3 behaves as word size.
- R10: A zero offset, whether from the immediate or from the register, in offset mode gives addr_o equal to base_i. This is register-indirect addressing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Unsigned immediate offset |
| roff_i | input | 32 | Register offset value |
| use_reg_i | input | 1 | 1 selects roff_i as the offset, 0 selects imm_i |
| sub_i | input | 1 | 1 subtracts the offset from the base |
| mode_i | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 reserved (acts as offset) |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved (acts as word) |
| addr_o | output | 32 | Effective address sent to memory |
| be_o | output | 4 | Byte-lane enables, bit n covers address byte n of a word |
| wb_base_o | output | 32 | New base value (base plus or minus offset) |
| wb_en_o | output | 1 | Base writeback enable |
| misalign_o | output | 1 | Misaligned halfword or word access |

## Verification
Random vectors drawn from a fixed seed cover every mode, size, offset source and direction. They separate pre-indexed from post-indexed addressing: both produce the same writeback value, but they send different addresses to memory whenever the offset is nonzero. Directed cases step the low two address bits through every value for each size, which exposes lane-mask and misalignment decoding errors. Further directed cases wrap the sum around zero in both directions, which exposes a wrong subtract or a missing carry. Zero-offset and reserved-code vectors confirm that register-indirect addressing and the fallback encodings behave as plain offset accesses and word accesses.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

   typedef enum logic [1:0] {
      IDX_OFFSET = 2'd0,
      IDX_PRE    = 2'd1,
      IDX_POST   = 2'd2,
      IDX_RSVD   = 2'd3
   } idx_mode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

endpackage

// File: rtl/lsag_offset_sel.sv
module lsag_offset_sel #(
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 12
) (
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [ADDR_W-1:0] roff_i,
   input  logic              use_reg_i,
   output logic [ADDR_W-1:0] off_o
);
   logic [ADDR_W-1:0] imm_ext;

   generate
      if (IMM_W == ADDR_W) begin : g_imm_full
         assign imm_ext = imm_i;
      end else begin : g_imm_zext
         assign imm_ext = {{(ADDR_W-IMM_W){1'b0}}, imm_i};
      end
   endgenerate

   assign off_o = use_reg_i ? roff_i : imm_ext;
endmodule

// File: rtl/lsag_addsub.sv
module lsag_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o
);
   // one adder: invert the operand and inject the carry for subtraction
   logic [W-1:0] b_eff;
   assign b_eff = b_i ^ {W{sub_i}};
   assign sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
endmodule

// File: rtl/lsag_lane_decode.sv
module lsag_lane_decode
   import lsag_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int LANE_AW = $clog2(LANES)
) (
   input  logic [LANE_AW-1:0] lo_i,
   input  acc_size_e          size_i,
   output logic [LANES-1:0]   be_o,
   output logic               misalign_o
);
   logic [LANE_AW-1:0] span;

   always_comb begin
      case (size_i)
         SZ_BYTE: span = '0;
         SZ_HALF: span = LANE_AW'(1);
         default: span = LANE_AW'(3);
      endcase
   end

   assign misalign_o = |(lo_i & span);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign be_o[g] = ((LANE_AW'(g) & ~span) == (lo_i & ~span));
      end
   endgenerate
endmodule

// File: rtl/lsag_top.sv
module lsag_top
   import lsag_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 12,
   parameter int LANES  = 4
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [ADDR_W-1:0] roff_i,
   input  logic              use_reg_i,
   input  logic              sub_i,
   input  logic [1:0]        mode_i,
   input  logic [1:0]        size_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [LANES-1:0]  be_o,
   output logic [ADDR_W-1:0] wb_base_o,
   output logic              wb_en_o,
   output logic              misalign_o
);
   localparam int LANE_AW = $clog2(LANES);

   generate
      if (LANES < 4 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("lsag_top: LANES must be a power of two of at least 4");
      end
      if (IMM_W < 1 || IMM_W > ADDR_W) begin : g_bad_imm
         $error("lsag_top: IMM_W must lie in 1..ADDR_W");
      end
      if (ADDR_W <= LANE_AW) begin : g_bad_addr
         $error("lsag_top: ADDR_W too small for lane count");
      end
   endgenerate

   idx_mode_e         mode;
   acc_size_e         size;
   logic [ADDR_W-1:0] off;
   logic [ADDR_W-1:0] sum;

   assign mode = idx_mode_e'(mode_i);
   assign size = acc_size_e'(size_i);

   lsag_offset_sel #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_off (
      .imm_i     (imm_i),
      .roff_i    (roff_i),
      .use_reg_i (use_reg_i),
      .off_o     (off)
   );

   lsag_addsub #(.W(ADDR_W)) u_add (
      .a_i   (base_i),
      .b_i   (off),
      .sub_i (sub_i),
      .sum_o (sum)
   );

   always_comb begin
      case (mode)
         IDX_PRE:  begin addr_o = sum;    wb_en_o = 1'b1; end
         IDX_POST: begin addr_o = base_i; wb_en_o = 1'b1; end
         default:  begin addr_o = sum;    wb_en_o = 1'b0; end
      endcase
   end

   assign wb_base_o = sum;

   lsag_lane_decode #(.LANES(LANES), .LANE_AW(LANE_AW)) u_lane (
      .lo_i       (addr_o[LANE_AW-1:0]),
      .size_i     (size),
      .be_o       (be_o),
      .misalign_o (misalign_o)
   );

   always_comb begin
      if (!$isunknown({base_i, imm_i, roff_i, use_reg_i, sub_i, mode_i, size_i})) begin
         assert_post_addr_R3: assert (mode_i != 2'd2 || addr_o == base_i)
            else $error("post-indexed address differs from base");
         assert_no_wb_offset_R1: assert (!(mode_i == 2'd0 || mode_i == 2'd3) || !wb_en_o)
            else $error("writeback in offset mode");
         assert_byte_onehot_R5: assert (size_i != 2'd0 || $countones(be_o) == 1)
            else $error("byte access not one-hot");
         assert_half_two_R6: assert (size_i != 2'd1 || $countones(be_o) == 2)
            else $error("halfword access lane count");
         assert_byte_aligned_R8: assert (size_i != 2'd0 || !misalign_o)
            else $error("byte access flagged misaligned");
         assert_pre_same_R2: assert (mode_i != 2'd1 || addr_o == wb_base_o)
            else $error("pre-indexed address differs from writeback");
      end
   end
endmodule

// File: tb/sim_lsag_top.sv
module sim_lsag_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] base_i = '0, roff_i = '0;
   logic [11:0] imm_i = '0;
   logic        use_reg_i = 1'b0, sub_i = 1'b0;
   logic [1:0]  mode_i = '0, size_i = '0;
   logic [31:0] addr_o, wb_base_o;
   logic [3:0]  be_o;
   logic        wb_en_o, misalign_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #2.5 clk = ~clk;

   lsag_top u0 (
      .base_i(base_i), .imm_i(imm_i), .roff_i(roff_i), .use_reg_i(use_reg_i),
      .sub_i(sub_i), .mode_i(mode_i), .size_i(size_i), .addr_o(addr_o),
      .be_o(be_o), .wb_base_o(wb_base_o), .wb_en_o(wb_en_o), .misalign_o(misalign_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_sum(input logic [31:0] b, input logic [11:0] im,
                                           input logic [31:0] ro, input logic ur, input logic sb);
      logic [31:0] off;
      off = ur ? ro : {20'd0, im};
      return sb ? b - off : b + off;
   endfunction

   function automatic logic [3:0] ref_be(input logic [1:0] lo, input logic [1:0] sz);
      if (sz == 2'd0) return 4'b0001 << lo;
      if (sz == 2'd1) return lo[1] ? 4'b1100 : 4'b0011;
      return 4'b1111;
   endfunction

   task automatic apply(input logic [31:0] b, input logic [11:0] im, input logic [31:0] ro,
                        input logic ur, input logic sb, input logic [1:0] md, input logic [1:0] sz);
      logic [31:0] s, ea;
      logic        wbe, mis;
      string       rm, rs;
      @(negedge clk);
      base_i = b; imm_i = im; roff_i = ro; use_reg_i = ur; sub_i = sb; mode_i = md; size_i = sz;
      #1;
      s   = ref_sum(b, im, ro, ur, sb);
      ea  = (md == 2'd2) ? b : s;
      wbe = (md == 2'd1 || md == 2'd2);
      mis = (sz == 2'd1) ? ea[0] : (sz == 2'd0) ? 1'b0 : (ea[1:0] != 2'd0);
      rm  = (md == 2'd1) ? "R2 addr" : (md == 2'd2) ? "R3 addr" : (md == 2'd3) ? "R9 addr" : "R1 addr";
      rs  = (sz == 2'd0) ? "R5 be" : (sz == 2'd1) ? "R6 be" : (sz == 2'd2) ? "R7 be" : "R9 be";
      chk(rm, addr_o, ea);
      chk("R4 wb_base", wb_base_o, s);
      chk((md == 2'd3) ? "R9 wb_en" : (md == 2'd0) ? "R1 wb_en" : "R2/R3 wb_en", {31'd0, wb_en_o}, {31'd0, wbe});
      chk(rs, {28'd0, be_o}, {28'd0, ref_be(ea[1:0], sz)});
      chk("R8 misalign", {31'd0, misalign_o}, {31'd0, mis});
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset-state check: all-zero inputs give a zero byte access at address 0
      #1;
      chk("R10 idle addr", addr_o, 32'd0);
      chk("R5 idle be", {28'd0, be_o}, 32'd1);
      // R10 register-indirect, both offset sources
      apply(32'h1234_5678, 12'd0, 32'd0, 1'b0, 1'b0, 2'd0, 2'd2);
      apply(32'hDEAD_BEEC, 12'd0, 32'd0, 1'b1, 1'b1, 2'd0, 2'd2);
      // R4 wrap-around in both directions
      apply(32'h0000_0002, 12'd4, 32'd0, 1'b0, 1'b1, 2'd1, 2'd0);
      apply(32'hFFFF_FFFF, 12'd1, 32'd0, 1'b0, 1'b0, 2'd1, 2'd0);
      apply(32'h8000_0000, 12'd0, 32'hFFFF_FFFF, 1'b1, 1'b1, 2'd2, 2'd2);
      // R3 post vs R2 pre with same operands
      apply(32'h0000_1000, 12'h010, 32'd0, 1'b0, 1'b0, 2'd2, 2'd2);
      apply(32'h0000_1000, 12'h010, 32'd0, 1'b0, 1'b0, 2'd1, 2'd2);
      // R5..R8 every low address pair for every size, R9 reserved codes
      for (int sz = 0; sz < 4; sz++)
         for (int lo = 0; lo < 4; lo++)
            apply(32'h0000_4000 | 32'(lo), 12'd0, 32'd0, 1'b0, 1'b0, 2'(sz), 2'(sz));
      apply(32'h0000_0100, 12'h003, 32'd0, 1'b0, 1'b0, 2'd3, 2'd3);
      // constrained random
      for (int i = 0; i < 2000; i++)
         apply($urandom, 12'($urandom), $urandom, 1'($urandom), 1'($urandom),
               2'($urandom), 2'($urandom));
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule